// File: doc/BRIEF.md
# Banked Lane Conflict Resolver

This block fronts a scratchpad made of sixteen independent 32-bit banks and serves a group of sixteen lanes at once. A request carries, for every lane, a valid bit, a word address, a write enable and write data. The word address picks its bank through its low bits and its row through the remaining bits. The resolver runs passes, one per clock cycle, until every valid lane has been served. When it finishes it returns one read word for each lane and a count of the passes it needed.

In each pass every bank looks at the lanes that still wait on it. It chooses the word of the lowest-numbered waiting lane and serves every waiting lane that names that same word. Reads of one word are therefore broadcast, and only different words that land in the same bank cost extra passes. Writes to one word within a pass are merged, and the highest-numbered lane wins. A read in the same pass as a write to its word returns the value the word held before that pass.

The controller has three states. `ST_IDLE` accepts a request. It moves to `ST_PASS` when any lane is valid and to `ST_DONE` when none is. `ST_PASS` stays in place while lanes remain unserved and moves to `ST_DONE` on the pass that serves the last lane. `ST_DONE` presents the response for one cycle and returns to `ST_IDLE`.

Top module: `lane_bank_resolver`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The bank of a lane is address bits [3:0] and its row is bits [7:4]. When all valid lanes name different banks, the request completes in one pass, and each reading lane gets the word stored at its address.
- R3: `rsp_degree` equals the largest number of distinct words requested within any single bank. `rsp_valid` goes high on the `rsp_degree`-th rising edge after the edge that accepted the request.
- R4: Any number of lanes reading the same word are served in a single pass, and each of them receives that word.
- R5: When several lanes write the same word in one request, the word afterwards holds the data of the highest-numbered writing lane.
- R6: A lane reading a word that the same request writes receives the value from before the request. Writing lanes and invalid lanes return 0 in their `rsp_rdata` slot.
- R7: From the accepting edge until the response cycle ends, `req_ready` is 0. A `req_valid` raised during that time changes neither the memory nor the response.
- R8: A request with no valid lane completes with `rsp_degree` 0, and `rsp_valid` goes high right after the accepting edge.
- R9: `rsp_valid` is high for exactly one cycle. `rsp_rdata` and `rsp_degree` keep their values after it until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered on the lane inputs |
| req_ready | output | 1 | The resolver is idle and takes a request this cycle |
| lane_vld | input | 16 | One valid bit for each lane |
| lane_we | input | 16 | Write enable for each lane (1 = write, 0 = read) |
| lane_addr | input | 128 | Eight-bit word address for each lane, lane n at bits [8n+7:8n] |
| lane_wdata | input | 512 | Write data for each lane, lane n at bits [32n+31:32n] |
| rsp_valid | output | 1 | One-cycle pulse: the request is complete |
| rsp_rdata | output | 512 | Read data for each lane, in the same layout as `lane_wdata` |
| rsp_degree | output | 5 | Number of passes the request needed |

## Verification
Within one pass, a bank can broadcast a read and merge colliding writes to the same word. Across banks, the same pass can serve lanes while another bank still has conflicts waiting. The bench provokes this with requests that read and write one word from several lanes in one go, mixed with lanes that pile different words onto one bank. It judges the result three ways. The readers must see the old value. A later read-back must return the highest writer's data. The pass count and the response latency must equal the per-bank distinct-word maximum, which the bench computes on its own.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DONE = 2'd2
    } lbr_state_e;

endpackage

// File: rtl/bank_lane_select.sv
// Per-bank pass selector: finds the lowest waiting lane aimed at this bank,
// serves every waiting lane naming the same word, merges writes (top lane wins).
module bank_lane_select #(
    parameter int LANES     = 16,
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int BANK_BITS = 4,
    parameter int BANK_ID   = 0
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*AW-1:0]     addr_flat,
    input  logic [LANES-1:0]        we,
    input  logic [LANES*DW-1:0]     wdata_flat,
    output logic [LANES-1:0]        hit,
    output logic [AW-BANK_BITS-1:0] row,
    output logic                    wr_en,
    output logic [DW-1:0]           wr_data
);

    logic          found;
    logic [AW-1:0] lead;

    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] &&
                addr_flat[l*AW +: BANK_BITS] == BANK_BITS'(BANK_ID)) begin
                found = 1'b1;
                lead  = addr_flat[l*AW +: AW];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            hit[l] = found && pending[l] && (addr_flat[l*AW +: AW] == lead);
        end
        row = lead[AW-1:BANK_BITS];
    end

    // ascending scan: the last matching writer (highest lane) remains
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (hit[l] && we[l]) begin
                wr_en   = 1'b1;
                wr_data = wdata_flat[l*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/bank_word_store.sv
// One bank: asynchronous read of the selected row, write at the clock edge.
module bank_word_store #(
    parameter int DW    = 32,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic [ROW_W-1:0] row,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data
);

    localparam int ROWS = 1 << ROW_W;

    logic [DW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wr_data;
        end
    end

    assign rd_data = mem[row];

endmodule

// File: rtl/lane_bank_resolver.sv
module lane_bank_resolver
    import lbr_pkg::*;
#(
    parameter int  LANES = 16,
    parameter int  BANKS = 16,
    parameter int  DW    = 32,
    parameter int  AW    = 8,
    localparam int DEG_W = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    lane_vld,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                rsp_valid,
    output logic [LANES*DW-1:0] rsp_rdata,
    output logic [DEG_W-1:0]    rsp_degree
);

    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ROW_W     = AW - BANK_BITS;

    lbr_state_e state_q, state_d;

    logic [LANES-1:0]    pending_q;
    logic [LANES-1:0]    we_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*DW-1:0] wdata_q;
    logic [LANES*DW-1:0] rdata_q;
    logic [DEG_W-1:0]    deg_q;

    logic [LANES-1:0] hit_b  [BANKS];
    logic [ROW_W-1:0] row_b  [BANKS];
    logic [DW-1:0]    wdat_b [BANKS];
    logic [DW-1:0]    rdat_b [BANKS];
    logic [BANKS-1:0] sel_wen;
    logic [LANES-1:0] served;
    logic [DW-1:0]    lane_rd [LANES];
    logic             in_pass;
    logic             accept;

    assign in_pass = (state_q == ST_PASS);
    assign accept  = req_valid && (state_q == ST_IDLE);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_lane_select #(
            .LANES(LANES), .AW(AW), .DW(DW),
            .BANK_BITS(BANK_BITS), .BANK_ID(b)
        ) u_sel (
            .pending    (pending_q),
            .addr_flat  (addr_q),
            .we         (we_q),
            .wdata_flat (wdata_q),
            .hit        (hit_b[b]),
            .row        (row_b[b]),
            .wr_en      (sel_wen[b]),
            .wr_data    (wdat_b[b])
        );

        bank_word_store #(.DW(DW), .ROW_W(ROW_W)) u_store (
            .clk     (clk),
            .row     (row_b[b]),
            .wr_en   (sel_wen[b] & in_pass),
            .wr_data (wdat_b[b]),
            .rd_data (rdat_b[b])
        );

        // every lane a bank serves belongs to that bank and names its row
        for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
            p_hit_in_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hit_b[b][l] |-> (addr_q[l*AW +: BANK_BITS] == BANK_BITS'(b)) &&
                                (addr_q[l*AW + BANK_BITS +: ROW_W] == row_b[b]));
        end
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | hit_b[b];
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = rdat_b[addr_q[l*AW +: BANK_BITS]];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = (|lane_vld) ? ST_PASS : ST_DONE;
            ST_PASS: if ((pending_q & ~served) == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_PASS: ;
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_rdata  = rdata_q;
    assign rsp_degree = deg_q;

    // request capture and per-pass bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            we_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            deg_q     <= '0;
        end else if (accept) begin
            pending_q <= lane_vld;
            we_q      <= lane_we;
            addr_q    <= lane_addr;
            wdata_q   <= lane_wdata;
            rdata_q   <= '0;
            deg_q     <= '0;
        end else if (in_pass) begin
            pending_q <= pending_q & ~served;
            deg_q     <= deg_q + 1'b1;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !we_q[l]) begin
                    rdata_q[l*DW +: DW] <= lane_rd[l];
                end
            end
        end
    end

    // each pass serves only waiting lanes and serves at least one
    p_pass_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |-> ((served & ~pending_q) == '0) && (served != '0));

    p_pending_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |=> $countones(pending_q) < $countones($past(pending_q)));

    p_degree_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_degree <= DEG_W'(LANES));

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> $stable(rsp_rdata) && $stable(rsp_degree));

endmodule

// File: tb/lane_bank_resolver_tb_top.sv
`timescale 1ns/1ps
module lane_bank_resolver_tb_top;

    localparam int LANES = 16;
    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int DEG_W = 5;
    localparam int WORDS = 256;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [LANES-1:0]    lane_vld;
    logic [LANES-1:0]    lane_we;
    logic [LANES*AW-1:0] lane_addr;
    logic [LANES*DW-1:0] lane_wdata;
    logic                rsp_valid;
    logic [LANES*DW-1:0] rsp_rdata;
    logic [DEG_W-1:0]    rsp_degree;

    logic [AW-1:0]    t_addr  [LANES];
    logic [DW-1:0]    t_wdata [LANES];
    logic [LANES-1:0] t_vld;
    logic [LANES-1:0] t_we;
    logic [DW-1:0]    model   [WORDS];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        lane_vld = t_vld;
        lane_we  = t_we;
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*AW +: AW]  = t_addr[l];
            lane_wdata[l*DW +: DW] = t_wdata[l];
        end
    end

    lane_bank_resolver dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .lane_vld   (lane_vld),
        .lane_we    (lane_we),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_degree (rsp_degree)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA5C3_0000 ^ (32'(a) * 32'h0101_0101);
    endfunction

    task automatic clear_req();
        t_vld = '0;
        t_we  = '0;
        for (int l = 0; l < LANES; l++) begin
            t_addr[l]  = '0;
            t_wdata[l] = '0;
        end
    endtask

    // issue the staged request, check degree, latency, data and response hold
    task automatic run_req(input string req, input bit hammer);
        logic [DW-1:0] exp_rd [LANES];
        logic [LANES*DW-1:0] held;
        int exp_deg;
        int lat;
        bit busy_ok;
        exp_deg = 0;
        for (int b = 0; b < 16; b++) begin
            int cnt;
            cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                bit seen;
                seen = 0;
                if (t_vld[l] && t_addr[l][3:0] == 4'(b)) begin
                    for (int k = 0; k < l; k++)
                        if (t_vld[k] && t_addr[k] == t_addr[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > exp_deg) exp_deg = cnt;
        end
        for (int l = 0; l < LANES; l++)
            exp_rd[l] = (t_vld[l] && !t_we[l]) ? model[t_addr[l]] : '0;
        for (int l = 0; l < LANES; l++)
            if (t_vld[l] && t_we[l]) model[t_addr[l]] = t_wdata[l];

        @(negedge clk);
        check(req_ready == 1'b1, req, "ready before issue", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hammer) begin
            t_vld = '1;
            t_we  = '1;
            for (int l = 0; l < LANES; l++) t_wdata[l] = 32'hDEAD_0000 | 32'(l);
        end else begin
            req_valid = 1'b0;
        end
        lat = 0;
        busy_ok = 1;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) busy_ok = 0;
            lat++;
            @(negedge clk);
        end
        if (req_ready) busy_ok = 0;
        req_valid = 1'b0;
        check(busy_ok, "R7", {req, " ready low while busy"}, 32'(busy_ok), 32'd1);
        check(lat == exp_deg, "R3", {req, " response latency"}, 32'(lat), 32'(exp_deg));
        check(32'(rsp_degree) == 32'(exp_deg), "R3", {req, " degree"},
              32'(rsp_degree), 32'(exp_deg));
        for (int l = 0; l < LANES; l++)
            check(rsp_rdata[l*DW +: DW] === exp_rd[l], req,
                  $sformatf("lane %0d rdata", l), rsp_rdata[l*DW +: DW], exp_rd[l]);
        held = rsp_rdata;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9", {req, " pulse one cycle"}, 32'(rsp_valid), 32'd0);
        check(rsp_rdata == held && 32'(rsp_degree) == 32'(exp_deg), "R9",
              {req, " response held"}, 32'(rsp_degree), 32'(exp_deg));
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    endtask

    // R2: fill all words, one row per request (distinct banks)
    task automatic t_fill();
        for (int r = 0; r < 16; r++) begin
            clear_req();
            t_vld = '1;
            t_we  = '1;
            for (int l = 0; l < LANES; l++) begin
                t_addr[l]  = AW'(r*16 + l);
                t_wdata[l] = pat(r*16 + l);
            end
            run_req("R2", 0);
        end
    endtask

    // R2: reads spread over all banks at different rows
    task automatic t_spread();
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'((l*17) % 256);
        run_req("R2", 0);
    endtask

    // R3: full and partial bank conflicts
    task automatic t_conflict();
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(3 + 16*l);
        run_req("R3", 0);
        clear_req();
        t_vld = '1;
        for (int l = 0; l < 4; l++) t_addr[l] = AW'(5 + 16*l);
        for (int l = 4; l < LANES; l++) t_addr[l] = AW'(l + 16*(l % 3));
        run_req("R3", 0);
    endtask

    // R4: broadcast, alone and mixed with a conflict
    task automatic t_broadcast();
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(42);
        run_req("R4", 0);
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = (l < 8) ? AW'(7) : AW'(23);
        run_req("R4", 0);
        clear_req();
        t_vld = 16'h03FF;
        for (int l = 0; l < 6; l++) t_addr[l] = AW'(9);
        for (int l = 6; l < 10; l++) t_addr[l] = AW'(9 + 16*(l - 5));
        run_req("R4", 0);
    endtask

    // R5 and R6: write merging, read of old value, zero slots
    task automatic t_collide();
        clear_req();
        t_vld = '0;
        t_vld[2] = 1; t_we[2] = 1; t_addr[2] = 8'd100; t_wdata[2] = 32'h1111_0002;
        t_vld[9] = 1; t_we[9] = 1; t_addr[9] = 8'd100; t_wdata[9] = 32'h1111_0009;
        t_vld[14] = 1; t_we[14] = 1; t_addr[14] = 8'd100; t_wdata[14] = 32'h1111_000E;
        t_vld[5] = 1; t_addr[5] = 8'd100;
        t_vld[0] = 1; t_addr[0] = 8'd101;
        t_vld[11] = 1; t_we[11] = 1; t_addr[11] = 8'd200; t_wdata[11] = 32'h2222_000B;
        run_req("R6", 0);
        clear_req();
        t_vld[0] = 1; t_addr[0] = 8'd100;
        t_vld[1] = 1; t_addr[1] = 8'd200;
        run_req("R5", 0);
        clear_req();
        t_vld[0] = 1; t_we[0] = 1; t_addr[0] = 8'd116; t_wdata[0] = 32'h3333_0000;
        t_vld[1] = 1; t_we[1] = 1; t_addr[1] = 8'd132; t_wdata[1] = 32'h3333_0001;
        t_vld[3] = 1; t_we[3] = 1; t_addr[3] = 8'd116; t_wdata[3] = 32'h3333_0003;
        t_vld[4] = 1; t_addr[4] = 8'd132;
        run_req("R6", 0);
        clear_req();
        t_vld[0] = 1; t_addr[0] = 8'd116;
        t_vld[1] = 1; t_addr[1] = 8'd132;
        run_req("R5", 0);
    endtask

    // R7: req_valid held high with garbage writes while busy
    task automatic t_busy();
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(12 + 16*l);
        run_req("R7", 1);
        clear_req();
        t_vld = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(12 + 16*l);
        run_req("R7", 0);
    endtask

    // R8: empty request
    task automatic t_empty();
        clear_req();
        run_req("R8", 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_req();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_spread();
        t_conflict();
        t_broadcast();
        t_collide();
        t_busy();
        t_empty();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule